// File: doc/BRIEF.md
# Destructive-Read Core Memory Controller

This block is a memory controller built around a synthesizable model of a coincident-current core stack. Each word of the stack is spread over `W` parallel bit planes. A cell changes state only where one selected X drive and one selected Y drive cross. Reading a cell is destructive. The clear drive forces the addressed cells to zero, and every cell that held a one flips and sends a pulse on its plane's line. Writing can only set cells, so any bit that must stay zero is held back by driving that plane's line in its inhibit role during the set phase.

The host issues one of three request types through a ready/valid handshake: read, write, or read-modify-write. Every access is a full cycle made of three phases: clear, sense strobe, then set. For a read, the set phase restores the word that was just sensed. For a write, the sensed data is dropped and the new word is set. For a read-modify-write, the controller stops after the strobe with `hold` high. It waits until the host pulses `resume` with a new value, and then writes that value back. The length of each phase is a clock-cycle count set by a parameter.

Top module: `core_stack_ctrl`

## Requirements
- R1: `req_ready` is high exactly when no cycle is in progress (`busy` low), and a request is accepted on a rising edge where `req_valid` and `req_ready` are both high. The `req_op` encoding is 0 = read, 1 = write, 2 = read-modify-write, and 3 behaves as a read. After reset the controller is idle with `rd_valid`, `cycle_done`, `hold` and all drives low, and every cell holds 0.
- R2: The low `XW` address bits select bit `addr % 2^XW` of `x_drive`, and the high `YW` bits select bit `addr / 2^XW` of `y_drive`. During the clear and set phases exactly one bit of each is high. In every other cycle both are zero.
- R3: `drive_set` is 0 while the drives are active in the clear phase and 1 while they are active in the set phase.
- R4: For read and read-modify-write, `rd_valid` pulses for one cycle, `CLR_CYC+STB_CYC` cycles after the accepting edge, and `rd_data` then holds the word stored before the access. A write does not raise `rd_valid`.
- R5: A read restores the word it destroyed, so reading the same address again returns the same value.
- R6: In the strobe phase, `line_inhibit` is 0 and `plane_line` carries the sensed word (one bit per plane). In the set phase, `line_inhibit` is 1 and `plane_line` bit i is 1 exactly where bit i of the word being written is 0. Both are 0 when idle.
- R7: A write replaces the whole word, including turning 1 bits into 0, because the clear phase runs before the set phase.
- R8: For read-modify-write, `hold` rises after the strobe and stays high until `resume` is sampled high. The word written back is `resume_data` from that edge, not the word that was read.
- R9: A read or write keeps `busy` high for exactly `CLR_CYC+STB_CYC+WR_CYC` cycles. `cycle_done` is high for the single cycle in which `busy` first returns low.
- R10: An access changes only the addressed word. Every other word keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle, request may be taken |
| req_op | input | 2 | 0 read, 1 write, 2 read-modify-write, 3 read |
| req_addr | input | XW+YW | Word address |
| req_wdata | input | W | Data for a write |
| rd_data | output | W | Word sensed by the last read or read-modify-write |
| rd_valid | output | 1 | One-cycle pulse when `rd_data` updates |
| busy | output | 1 | An access cycle is in progress |
| hold | output | 1 | Read-modify-write paused, waiting for `resume` |
| resume | input | 1 | Continue a paused read-modify-write |
| resume_data | input | W | Word written back on resume |
| cycle_done | output | 1 | One-cycle pulse at the end of each access |
| x_drive | output | 2^XW | X select lines |
| y_drive | output | 2^YW | Y select lines |
| drive_set | output | 1 | Drive direction: 0 clears, 1 sets |
| line_inhibit | output | 1 | Shared plane line in inhibit role (1) or sense role (0) |
| plane_line | output | W | Per-plane sense pulse or inhibit level |

## Verification
The bench builds the block with its default parameters: a 4 x 4 select grid (16 words), 8 planes, and phases of 2, 1 and 2 cycles. With only 16 words, every address can be written, read twice and put through a read-modify-write. At every cycle of every access, the bench checks the X/Y decode, the phase-by-phase use of the shared line and the phase timing. A single-word overwrite followed by a read of all 16 words shows both the 1-to-0 behaviour of writes and that neighbouring words are left alone.

// File: rtl/core_stack_ctrl.sv
module core_stack_ctrl #(
  parameter int XW      = 2,
  parameter int YW      = 2,
  parameter int W       = 8,
  parameter int CLR_CYC = 2,
  parameter int STB_CYC = 1,
  parameter int WR_CYC  = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [1:0]           req_op,
  input  logic [XW+YW-1:0]     req_addr,
  input  logic [W-1:0]         req_wdata,
  output logic [W-1:0]         rd_data,
  output logic                 rd_valid,
  output logic                 busy,
  output logic                 hold,
  input  logic                 resume,
  input  logic [W-1:0]         resume_data,
  output logic                 cycle_done,
  output logic [(1<<XW)-1:0]   x_drive,
  output logic [(1<<YW)-1:0]   y_drive,
  output logic                 drive_set,
  output logic                 line_inhibit,
  output logic [W-1:0]         plane_line
);
  localparam int NX    = 1 << XW;
  localparam int NY    = 1 << YW;
  localparam int DEPTH = NX * NY;
  localparam int MAXC  = (CLR_CYC > STB_CYC) ? ((CLR_CYC > WR_CYC) ? CLR_CYC : WR_CYC)
                                             : ((STB_CYC > WR_CYC) ? STB_CYC : WR_CYC);
  localparam int CW    = $clog2(MAXC + 1);

  typedef enum logic [2:0] {S_IDLE, S_CLR, S_STB, S_HOLD, S_WR} st_t;

  st_t             st;
  logic [CW-1:0]   cnt, plen;
  logic [XW+YW-1:0] addr_q;
  logic            rmw_q, wr_q;
  logic [W-1:0]    data_q, snap_q, flip;
  logic [W-1:0]    mem [DEPTH];
  logic            drive_on, last;

  assign busy         = (st != S_IDLE);
  assign req_ready    = !busy;
  assign hold         = (st == S_HOLD);
  assign drive_on     = (st == S_CLR) || (st == S_WR);
  assign x_drive      = drive_on ? (NX'(1) << addr_q[XW-1:0]) : '0;
  assign y_drive      = drive_on ? (NY'(1) << addr_q[XW+YW-1:XW]) : '0;
  assign drive_set    = (st == S_WR);
  assign line_inhibit = (st == S_WR);
  assign plane_line   = (st == S_STB) ? snap_q : (st == S_WR) ? ~data_q : '0;

  always_comb begin
    case (st)
      S_CLR:   plen = CW'(CLR_CYC);
      S_STB:   plen = CW'(STB_CYC);
      default: plen = CW'(WR_CYC);
    endcase
  end
  assign last = (cnt == plen - CW'(1));

  always_comb begin
    flip = '0;
    for (int y = 0; y < NY; y++)
      for (int x = 0; x < NX; x++)
        if (x_drive[x] && y_drive[y]) flip = flip | mem[y*NX + x];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      for (int y = 0; y < NY; y++)
        for (int x = 0; x < NX; x++)
          if (x_drive[x] && y_drive[y]) begin
            if (!drive_set && cnt == '0) mem[y*NX + x] <= '0;
            else if (drive_set && last)  mem[y*NX + x] <= mem[y*NX + x] | ~plane_line;
          end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; addr_q <= '0; rmw_q <= 1'b0; wr_q <= 1'b0;
      data_q <= '0; snap_q <= '0; rd_data <= '0; rd_valid <= 1'b0; cycle_done <= 1'b0;
    end else begin
      rd_valid   <= 1'b0;
      cycle_done <= 1'b0;
      cnt        <= cnt + CW'(1);
      case (st)
        S_IDLE: if (req_valid) begin
          st <= S_CLR; cnt <= '0; addr_q <= req_addr;
          rmw_q <= (req_op == 2'd2); wr_q <= (req_op == 2'd1); data_q <= req_wdata;
        end
        S_CLR: begin
          if (cnt == '0) snap_q <= flip;
          if (last) begin st <= S_STB; cnt <= '0; end
        end
        S_STB: if (last) begin
          rd_data  <= snap_q;
          rd_valid <= !wr_q;
          cnt      <= '0;
          if (rmw_q) st <= S_HOLD;
          else begin
            st <= S_WR;
            if (!wr_q) data_q <= snap_q;
          end
        end
        S_HOLD: if (resume) begin
          st <= S_WR; cnt <= '0; data_q <= resume_data;
        end
        S_WR: if (last) begin
          st <= S_IDLE; cnt <= '0; cycle_done <= 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R2
  x_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(x_drive) && $onehot0(y_drive));
  // R2
  xy_pair_chk: assert property (@(posedge clk) disable iff (!rst_n) (|x_drive) == (|y_drive));
  // R6
  duty_chk: assert property (@(posedge clk) disable iff (!rst_n) ((|x_drive) && !drive_set) |-> !line_inhibit);
  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) cycle_done |-> req_ready);
  // R8
  hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n) (hold && !resume) |=> hold);
  // R4
  rdv_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) rd_valid |=> !rd_valid);
endmodule

// File: tb/core_stack_ctrl_test.sv
module core_stack_ctrl_test;
  localparam int TCLK = 10;
  localparam int XW = 2, YW = 2, W = 8, C = 2, S = 1, WC = 2;
  localparam int NX = 1 << XW, DEPTH = 1 << (XW + YW);

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, resume = 0;
  logic [1:0] req_op = '0;
  logic [XW+YW-1:0] req_addr = '0;
  logic [W-1:0] req_wdata = '0, resume_data = '0;
  logic req_ready, rd_valid, busy, hold, cycle_done, drive_set, line_inhibit;
  logic [W-1:0] rd_data, plane_line;
  logic [NX-1:0] x_drive;
  logic [(1<<YW)-1:0] y_drive;

  int errors = 0, checks = 0;
  logic [W-1:0] model [DEPTH];

  always #(TCLK/2) clk = ~clk;

  core_stack_ctrl #(.XW(XW), .YW(YW), .W(W), .CLR_CYC(C), .STB_CYC(S), .WR_CYC(WC)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_addr(req_addr), .req_wdata(req_wdata), .rd_data(rd_data), .rd_valid(rd_valid),
    .busy(busy), .hold(hold), .resume(resume), .resume_data(resume_data),
    .cycle_done(cycle_done), .x_drive(x_drive), .y_drive(y_drive), .drive_set(drive_set),
    .line_inhibit(line_inhibit), .plane_line(plane_line));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // op: 0 read, 1 write, 2 rmw, 3 read
  task automatic access(input int op, input int a, input logic [W-1:0] nv);
    logic [W-1:0] old, wv;
    int n, rdv_at, bad_dec, bad_dir, bad_line, prev_drv;
    old = model[a];
    wv = (op == 1 || op == 2) ? nv : old;
    n = 0; rdv_at = -1; bad_dec = 0; bad_dir = 0; bad_line = 0; prev_drv = 0;
    @(negedge clk);
    req_valid = 1; req_op = 2'(op); req_addr = (XW+YW)'(a); req_wdata = nv; resume_data = nv;
    @(negedge clk);
    req_valid = 0;
    while (busy) begin
      n++;
      if (rd_valid) rdv_at = n;
      if (|x_drive) begin
        if (x_drive != NX'(1) << (a % NX) || y_drive != 4'(1) << (a / NX)) bad_dec++;
        if (drive_set != (n > C)) bad_dir++;
        if (drive_set && (!line_inhibit || plane_line != ~wv)) bad_line++;
      end else if (!hold) begin
        if (line_inhibit || plane_line != old) bad_line++;
        if (y_drive != '0) bad_dec++;
      end
      if (hold) begin
        resume = 1;
        @(negedge clk);
        resume = 0;
        n++;
      end else @(negedge clk);
    end
    chk(bad_dec == 0, "R2 xy decode", bad_dec, 0);
    chk(bad_dir == 0, "R3 drive direction", bad_dir, 0);
    chk(bad_line == 0, "R6 sense/inhibit line", bad_line, 0);
    chk(cycle_done && req_ready, "R9 cycle_done at end", cycle_done, 1);
    if (op != 2) chk(n == C + S + WC, "R9 busy length", n, C + S + WC);
    if (op == 1) chk(rdv_at == -1, "R4 no rd_valid on write", rdv_at, -1);
    else begin
      chk(rdv_at == C + S + 1, "R4 rd_valid timing", rdv_at, C + S + 1);
      chk(rd_data == old, op == 2 ? "R8 rmw old data" : "R4 read data", rd_data, old);
    end
    model[a] = wv;
    @(negedge clk);
    chk(!cycle_done, "R9 cycle_done single pulse", cycle_done, 0);
  endtask

  task automatic read_all(input string tag);
    for (int a = 0; a < DEPTH; a++) begin
      logic [W-1:0] e;
      e = model[a];
      access(0, a, '0);
      chk(rd_data == e, tag, rd_data, e);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int a = 0; a < DEPTH; a++) model[a] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready && !busy && !rd_valid && !cycle_done && !hold, "R1 reset idle", busy, 0);
    chk(x_drive == '0 && y_drive == '0 && plane_line == '0, "R1 reset drives", x_drive, 0);
    read_all("R1 reset contents zero");
    for (int a = 0; a < DEPTH; a++) access(1, a, W'(a * 29 + 7));
    read_all("R5 first read after write");
    read_all("R5 restore on reread");
    access(1, 5, 8'h00);
    read_all("R7 R10 overwrite to zero, neighbours kept");
    access(1, 9, 8'hFF);
    access(1, 9, 8'h5A);
    read_all("R7 R10 partial clear");
    for (int a = 0; a < DEPTH; a++) access(2, a, model[a] + 8'd1);
    read_all("R8 rmw written back");
    access(3, 3, '0);
    chk(rd_data == model[3], "R1 op 3 reads", rd_data, model[3]);
    read_all("R5 after op 3");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule